// File: doc/BRIEF.md
# Debug Trigger Priority Sequencer

This block sits between the trigger sources of an on-chip debug unit and its state sequencer. In any cycle several sources can fire together: a breakpoint request from a coprocessor, a software immediate-trigger write, an external tag hit, and four comparator match channels. The block picks exactly one of them by a fixed priority and throws the rest away. It then moves a small state register through its disarmed, intermediate and final states. The target for each comparator match comes from a per-state configuration word.

Leaving the sequencer can raise a forced breakpoint. The breakpoint carries a flag that chooses between a background debug entry and a software interrupt. How the trigger behaves depends on the trace alignment. With begin or mid alignment, the trigger parks the sequencer in the final state and delays the breakpoint until the trace finishes. With end alignment, or with tracing off, the trigger ends the session at once. Software arms and disarms the unit through two write strobes. A hardware disarm that lands in the same cycle as an arm write overrides it.

Top module: `dbg_trig_seq`

## Requirements
- R1: Synchronous reset gives `seq_state` 0, `armed` 0 and all three pulse outputs low, and it drops any deferred breakpoint.
- R2: While disarmed (state 0), `arm_wr` moves the state to 1 and sets `armed` in the next cycle. In state 0 every trigger except R3's is ignored. `armed` is 1 exactly when the state is not 0.
- R3: When `cop_brk_req` and `cop_brk_en` are both high, `brk_req` pulses in the next cycle and `brk_to_bdm` equals `bdm_sel`, whatever `brk_en` is. The sequencer returns to state 0 and disarms, and `trace_term` pulses if the unit was armed. When `cop_brk_en` is low the request has no effect.
- R4: In begin (`align_mode`=1) or mid (2) alignment, an accepted `imm_trig` sends the state to the final value 4. If `brk_en` is set, the breakpoint is held back. `trace_done` in state 4 returns the state to 0 and pulses `brk_req` only if a breakpoint was held back.
- R5: In end alignment (3) or with tracing off (0), an accepted `imm_trig` returns the state to 0 and disarms. `brk_req` pulses in the next cycle when `brk_en` is set.
- R6: An accepted `tag_hit` returns the state to 0 and disarms, with no breakpoint.
- R7: In states 1 to 3, the matching channel with the lowest number wins. The state becomes that channel's 3-bit field of `next_cfg`, at bit offset ((state-1)*4+channel)*3. A target of 0 disarms. A channel whose field is above 4 is treated as not matching. Matches are ignored in state 4.
- R8: A matching channel whose target is 4 beats every other matching channel, whatever its number. The R4/R5 alignment rule then applies, as for `imm_trig`.
- R9: When `range_mode` is set and channels 0 and 2 match together, channel 2 is ignored.
- R10: Priority from highest to lowest is coprocessor breakpoint, `imm_trig`, `tag_hit`, `trace_done` in state 4, comparator matches. Lower sources in the same cycle are dropped.
- R11: A hardware disarm wins over an `arm_wr` in the same cycle. Hardware disarms come from R3, R5, R6, a 0 target, or `trace_done`.
- R12: `brk_req` and `trace_term` are registered one-cycle pulses, and `trace_term` only appears together with `brk_req`.
- R13: Absent a hardware event, `disarm_wr` returns the state to 0, clears `armed` and drops a deferred breakpoint. It wins over `arm_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cop_brk_req | input | 1 | Coprocessor breakpoint request |
| cop_brk_en | input | 1 | Enable for the coprocessor breakpoint path |
| bdm_sel | input | 1 | 1: breakpoint enters debug mode, 0: software interrupt |
| imm_trig | input | 1 | Software immediate-trigger write |
| tag_hit | input | 1 | External tag hit |
| match_in | input | N_CH | Comparator match channels, bit 0 highest priority |
| range_mode | input | 1 | Pairs channel 0 with channel 2 |
| arm_wr | input | 1 | Software arm write |
| disarm_wr | input | 1 | Software disarm write |
| align_mode | input | 2 | 0 off, 1 begin, 2 mid, 3 end |
| brk_en | input | 1 | Breakpoint enable for sequencer triggers |
| trace_done | input | 1 | Trace has finished filling |
| next_cfg | input | N_MID*N_CH*ST_W | Next-state field per intermediate state and channel |
| seq_state | output | ST_W | Current sequencer state |
| armed | output | 1 | Armed flag |
| brk_req | output | 1 | Forced breakpoint pulse |
| brk_to_bdm | output | 1 | Breakpoint kind, valid with brk_req |
| trace_term | output | 1 | Trace terminate pulse |

## Verification
A pseudo-random sweep drives every source at tuned rates. The configuration words are redrawn regularly, and alignment and range mode step through all their combinations. This makes coincident triggers common. Those cycles separate a correct priority order from a swapped one. They also show a final-state target beating a lower channel number, and channel 2 being dropped in range mode. Rare coprocessor requests and frequent arm writes land together often enough to tell a hardware disarm that wins from one that loses. Stepping the alignment through all four values separates the deferred breakpoint from the immediate one.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_COP,
    EV_IMM,
    EV_TAG,
    EV_DONE,
    EV_MATCH
  } trig_ev_t;

  localparam logic [1:0] AL_OFF   = 2'd0;
  localparam logic [1:0] AL_BEGIN = 2'd1;
  localparam logic [1:0] AL_MID   = 2'd2;
  localparam logic [1:0] AL_END   = 2'd3;

endpackage

// File: rtl/dbg_match_sel.sv
module dbg_match_sel #(
  parameter int N_CH  = 4,
  parameter int N_MID = 3,
  parameter int ST_W  = 3,
  localparam int CFG_W = N_MID * N_CH * ST_W
) (
  input  logic [ST_W-1:0]  state,
  input  logic [N_CH-1:0]  match_in,
  input  logic             range_mode,
  input  logic [CFG_W-1:0] next_cfg,
  output logic             hit,
  output logic             to_final,
  output logic [ST_W-1:0]  nxt
);

  localparam logic [ST_W-1:0] FINAL_ST = ST_W'(N_MID + 1);

  logic            in_mid;
  logic [31:0]     row_base;
  logic [N_CH-1:0] eff;
  logic [N_CH-1:0] usable;
  logic [N_CH-1:0] fin;
  logic [ST_W-1:0] cand [N_CH];

  assign in_mid   = (state != '0) && (32'(state) <= 32'(N_MID));
  assign row_base = in_mid ? (32'(state) - 32'd1) * 32'(N_CH * ST_W) : 32'd0;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    // the paired channel of channel 0 drops out in range mode (R9)
    if (c == 2) begin : g_pair
      assign eff[c] = match_in[c] & ~(range_mode & match_in[0]);
    end else begin : g_plain
      assign eff[c] = match_in[c];
    end
    assign cand[c]   = next_cfg[row_base + 32'(c * ST_W) +: ST_W];
    assign usable[c] = eff[c] & in_mid & (cand[c] <= FINAL_ST);
    assign fin[c]    = usable[c] & (cand[c] == FINAL_ST);
  end

  always_comb begin
    nxt = '0;
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (usable[c]) nxt = cand[c];
    end
    if (|fin) begin
      for (int c = N_CH - 1; c >= 0; c--) begin
        if (fin[c]) nxt = cand[c];
      end
    end
  end

  assign hit      = |usable;
  assign to_final = |fin;

endmodule

// File: rtl/dbg_trig_arb.sv
module dbg_trig_arb
  import dbg_seq_pkg::*;
#(
  parameter int N_MID = 3,
  parameter int ST_W  = 3
) (
  input  logic            armed,
  input  logic [ST_W-1:0] state,
  input  logic            cop_go,
  input  logic            imm_trig,
  input  logic            tag_hit,
  input  logic            trace_done,
  input  logic            m_hit,
  output trig_ev_t        ev
);

  localparam logic [ST_W-1:0] FINAL_ST = ST_W'(N_MID + 1);

  always_comb begin
    ev = EV_NONE;
    if (cop_go)                               ev = EV_COP;
    else if (!armed)                          ev = EV_NONE;
    else if (imm_trig)                        ev = EV_IMM;
    else if (tag_hit)                         ev = EV_TAG;
    else if (state == FINAL_ST && trace_done) ev = EV_DONE;
    else if (m_hit)                           ev = EV_MATCH;
  end

endmodule

// File: rtl/dbg_seq_core.sv
module dbg_seq_core
  import dbg_seq_pkg::*;
#(
  parameter int N_MID = 3,
  parameter int ST_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  trig_ev_t        ev,
  input  logic            m_to_final,
  input  logic [ST_W-1:0] m_nxt,
  input  logic [1:0]      align_mode,
  input  logic            brk_en,
  input  logic            bdm_sel,
  input  logic            arm_wr,
  input  logic            disarm_wr,
  output logic [ST_W-1:0] state,
  output logic            armed,
  output logic            brk,
  output logic            brk_bdm,
  output logic            term
);

  localparam logic [ST_W-1:0] FINAL_ST = ST_W'(N_MID + 1);

  logic [ST_W-1:0] st_q, n_st;
  logic            arm_q, n_arm;
  logic            pend_q, n_pend;
  logic            d_brk, d_bdm, d_term;
  logic            hw_off, enter_fin, defer;

  assign defer = (align_mode == AL_BEGIN) || (align_mode == AL_MID);

  always_comb begin
    n_st      = st_q;
    n_arm     = arm_q;
    n_pend    = pend_q;
    d_brk     = 1'b0;
    d_bdm     = 1'b0;
    d_term    = 1'b0;
    hw_off    = 1'b0;
    enter_fin = 1'b0;
    case (ev)
      EV_COP: begin
        d_brk  = 1'b1;
        d_bdm  = bdm_sel;
        d_term = arm_q;
        hw_off = 1'b1;
      end
      EV_IMM: enter_fin = 1'b1;
      EV_TAG: hw_off = 1'b1;
      EV_DONE: begin
        d_brk  = pend_q;
        d_bdm  = pend_q & bdm_sel;
        hw_off = 1'b1;
      end
      EV_MATCH: begin
        if (m_to_final)      enter_fin = 1'b1;
        else if (m_nxt == '0) hw_off   = 1'b1;
        else                  n_st     = m_nxt;
      end
      default: ;
    endcase
    if (enter_fin) begin
      if (defer) begin
        n_st   = FINAL_ST;
        n_pend = pend_q | brk_en;
      end else begin
        hw_off = 1'b1;
        d_brk  = brk_en;
        d_bdm  = brk_en & bdm_sel;
      end
    end
    if (hw_off || disarm_wr) begin
      n_st   = '0;
      n_arm  = 1'b0;
      n_pend = 1'b0;
    end else if (arm_wr && !arm_q) begin
      n_st  = ST_W'(1);
      n_arm = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      arm_q   <= 1'b0;
      pend_q  <= 1'b0;
      brk     <= 1'b0;
      brk_bdm <= 1'b0;
      term    <= 1'b0;
    end else begin
      st_q    <= n_st;
      arm_q   <= n_arm;
      pend_q  <= n_pend;
      brk     <= d_brk;
      brk_bdm <= d_bdm;
      term    <= d_term;
    end
  end

  assign state = st_q;
  assign armed = arm_q;

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_seq_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int N_MID = 3,
  localparam int ST_W  = $clog2(N_MID + 2),
  localparam int CFG_W = N_MID * N_CH * ST_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cop_brk_req,
  input  logic             cop_brk_en,
  input  logic             bdm_sel,
  input  logic             imm_trig,
  input  logic             tag_hit,
  input  logic [N_CH-1:0]  match_in,
  input  logic             range_mode,
  input  logic             arm_wr,
  input  logic             disarm_wr,
  input  logic [1:0]       align_mode,
  input  logic             brk_en,
  input  logic             trace_done,
  input  logic [CFG_W-1:0] next_cfg,
  output logic [ST_W-1:0]  seq_state,
  output logic             armed,
  output logic             brk_req,
  output logic             brk_to_bdm,
  output logic             trace_term
);

  trig_ev_t        ev;
  logic            m_hit, m_to_final;
  logic [ST_W-1:0] m_nxt;

  dbg_match_sel #(.N_CH(N_CH), .N_MID(N_MID), .ST_W(ST_W)) u_match (
    .state      (seq_state),
    .match_in   (match_in),
    .range_mode (range_mode),
    .next_cfg   (next_cfg),
    .hit        (m_hit),
    .to_final   (m_to_final),
    .nxt        (m_nxt)
  );

  dbg_trig_arb #(.N_MID(N_MID), .ST_W(ST_W)) u_arb (
    .armed      (armed),
    .state      (seq_state),
    .cop_go     (cop_brk_req & cop_brk_en),
    .imm_trig   (imm_trig),
    .tag_hit    (tag_hit),
    .trace_done (trace_done),
    .m_hit      (m_hit),
    .ev         (ev)
  );

  dbg_seq_core #(.N_MID(N_MID), .ST_W(ST_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .ev         (ev),
    .m_to_final (m_to_final),
    .m_nxt      (m_nxt),
    .align_mode (align_mode),
    .brk_en     (brk_en),
    .bdm_sel    (bdm_sel),
    .arm_wr     (arm_wr),
    .disarm_wr  (disarm_wr),
    .state      (seq_state),
    .armed      (armed),
    .brk        (brk_req),
    .brk_bdm    (brk_to_bdm),
    .term       (trace_term)
  );

endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk #(
  parameter int N_MID = 3,
  parameter int ST_W  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            cop_brk_req,
  input logic            cop_brk_en,
  input logic            arm_wr,
  input logic [1:0]      align_mode,
  input logic [ST_W-1:0] seq_state,
  input logic            armed,
  input logic            brk_req,
  input logic            brk_to_bdm,
  input logic            trace_term
);

  localparam logic [ST_W-1:0] FINAL_ST = ST_W'(N_MID + 1);

  p_armed_state_r2: assert property (@(posedge clk) disable iff (rst)
    armed == (seq_state != '0));

  p_arm_entry_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> seq_state == ST_W'(1));

  p_brk_disarms_r3: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (seq_state == '0 && !armed));

  p_mode_qual_r3: assert property (@(posedge clk) disable iff (rst)
    brk_to_bdm |-> brk_req);

  p_state_range_r7: assert property (@(posedge clk) disable iff (rst)
    seq_state <= FINAL_ST);

  p_final_deferred_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_state == FINAL_ST && $past(seq_state) != FINAL_ST)
      |-> ($past(align_mode) == 2'd1 || $past(align_mode) == 2'd2));

  p_hw_wins_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(arm_wr) && $past(cop_brk_req) && $past(cop_brk_en)) |-> !armed);

  p_term_with_brk_r12: assert property (@(posedge clk) disable iff (rst)
    trace_term |-> brk_req);

endmodule

bind dbg_trig_seq dbg_trig_seq_chk #(.N_MID(N_MID), .ST_W(ST_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cop_brk_req (cop_brk_req),
  .cop_brk_en  (cop_brk_en),
  .arm_wr      (arm_wr),
  .align_mode  (align_mode),
  .seq_state   (seq_state),
  .armed       (armed),
  .brk_req     (brk_req),
  .brk_to_bdm  (brk_to_bdm),
  .trace_term  (trace_term)
);

// File: tb/dbg_trig_seq_test.sv
module dbg_trig_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_CH   = 4;
  localparam int N_MID  = 3;
  localparam int ST_W   = 3;
  localparam int CFG_W  = N_MID * N_CH * ST_W;
  localparam int N_STEP = 24000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cop_brk_req = 0, cop_brk_en = 0, bdm_sel = 0;
  logic             imm_trig = 0, tag_hit = 0, range_mode = 0;
  logic [N_CH-1:0]  match_in = '0;
  logic             arm_wr = 0, disarm_wr = 0, brk_en = 0, trace_done = 0;
  logic [1:0]       align_mode = 2'd0;
  logic [CFG_W-1:0] next_cfg = '0;
  logic [ST_W-1:0]  seq_state;
  logic             armed, brk_req, brk_to_bdm, trace_term;

  dbg_trig_seq #(.N_CH(N_CH), .N_MID(N_MID)) uut (
    .clk(clk), .rst(rst), .cop_brk_req(cop_brk_req), .cop_brk_en(cop_brk_en),
    .bdm_sel(bdm_sel), .imm_trig(imm_trig), .tag_hit(tag_hit),
    .match_in(match_in), .range_mode(range_mode), .arm_wr(arm_wr),
    .disarm_wr(disarm_wr), .align_mode(align_mode), .brk_en(brk_en),
    .trace_done(trace_done), .next_cfg(next_cfg), .seq_state(seq_state),
    .armed(armed), .brk_req(brk_req), .brk_to_bdm(brk_to_bdm),
    .trace_term(trace_term)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  logic done_flag = 1'b0;

  // reference state
  int   m_st   = 0;
  logic m_arm  = 0;
  logic m_pend = 0;
  logic e_brk = 0, e_bdm = 0, e_term = 0;
  string lbl = "R1";

  logic [31:0] lfsr = 32'hACE1_2468;

  function automatic logic [31:0] lfsr_next(input logic [31:0] v);
    return {v[30:0], 1'b0} ^ (v[31] ? 32'h0400_0007 : 32'h0);
  endfunction

  function automatic int cfg_of(input int s, input int c);
    return int'(next_cfg[((s - 1) * N_CH + c) * ST_W +: ST_W]);
  endfunction

  task automatic check(input string req);
    vectors++;
    if (seq_state !== ST_W'(m_st) || armed !== m_arm || brk_req !== e_brk ||
        brk_to_bdm !== e_bdm || trace_term !== e_term) begin
      fails++;
      $display("FAIL %s: got st=%0d arm=%0b brk=%0b bdm=%0b term=%0b exp st=%0d arm=%0b brk=%0b bdm=%0b term=%0b",
               req, seq_state, armed, brk_req, brk_to_bdm, trace_term,
               m_st, m_arm, e_brk, e_bdm, e_term);
    end
  endtask

  // reference model built from the requirements
  task automatic model_step();
    logic hw = 0;
    logic fin_entry = 0;
    int   srcs = 0;
    logic [N_CH-1:0] eff;
    int   fin_c = -1, low_c = -1;
    e_brk = 0; e_bdm = 0; e_term = 0;
    lbl = "R12";
    eff = match_in;
    if (range_mode && match_in[0]) eff[2] = 1'b0;
    if (m_st >= 1 && m_st <= N_MID) begin
      for (int c = 0; c < N_CH; c++) begin
        if (eff[c] && cfg_of(m_st, c) == 4 && fin_c < 0) fin_c = c;
        if (eff[c] && cfg_of(m_st, c) <= 4 && low_c < 0) low_c = c;
      end
    end
    srcs = int'(imm_trig) + int'(tag_hit) + int'(low_c >= 0) + int'(m_st == 4 && trace_done);
    if (cop_brk_req && cop_brk_en) begin
      e_brk = 1; e_bdm = bdm_sel; e_term = m_arm; hw = 1;
      lbl = (m_arm && srcs > 0) ? "R10" : "R3";
    end else if (m_arm) begin
      if (imm_trig) begin
        fin_entry = 1; lbl = (align_mode == 1 || align_mode == 2) ? "R4" : "R5";
      end else if (tag_hit) begin
        hw = 1; lbl = "R6";
      end else if (m_st == 4 && trace_done) begin
        e_brk = m_pend; e_bdm = m_pend & bdm_sel; hw = 1; lbl = "R4";
      end else if (fin_c >= 0) begin
        fin_entry = 1;
        lbl = (fin_c != low_c) ? "R8" : ((range_mode && match_in[0] && match_in[2]) ? "R9" : "R7");
      end else if (low_c >= 0) begin
        if (cfg_of(m_st, low_c) == 0) hw = 1;
        else m_st = cfg_of(m_st, low_c);
        lbl = (range_mode && match_in[0] && match_in[2]) ? "R9" : "R7";
      end
      if (srcs > 1) lbl = "R10";
    end
    if (fin_entry) begin
      if (align_mode == 2'd1 || align_mode == 2'd2) begin
        m_st = 4; m_pend = m_pend | brk_en;
      end else begin
        hw = 1; e_brk = brk_en; e_bdm = brk_en & bdm_sel;
      end
    end
    if (hw) begin
      m_st = 0; m_arm = 0; m_pend = 0;
      if (arm_wr) lbl = "R11";
    end else if (disarm_wr) begin
      m_st = 0; m_arm = 0; m_pend = 0; lbl = "R13";
    end else if (arm_wr && !m_arm) begin
      m_st = 1; m_arm = 1; lbl = "R2";
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected under 200000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1");
    for (int k = 0; k < N_STEP; k++) begin
      lfsr = lfsr_next(lfsr_next(lfsr_next(lfsr)));
      if (k % 512 == 0) begin
        for (int j = 0; j < CFG_W; j += 4) begin
          lfsr = lfsr_next(lfsr);
          next_cfg[j +: 4] = lfsr[7:4];
        end
        lfsr = lfsr_next(lfsr);
      end
      align_mode  = 2'(k / 64);
      range_mode  = k[8];
      cop_brk_req = (lfsr[3:0] == 4'd0);
      cop_brk_en  = lfsr[4] | lfsr[5];
      imm_trig    = (lfsr[9:6] == 4'd0);
      tag_hit     = (lfsr[13:10] == 4'd0);
      match_in    = lfsr[17:14] & lfsr[21:18];
      arm_wr      = lfsr[22];
      disarm_wr   = (lfsr[27:24] == 4'd0);
      trace_done  = lfsr[28] & lfsr[29];
      brk_en      = lfsr[30];
      bdm_sel     = lfsr[31];
      model_step();
      @(negedge clk);
      check(lbl);
    end
    // directed: arm write together with a coprocessor breakpoint while armed
    cop_brk_req = 0; imm_trig = 0; tag_hit = 0; match_in = '0; disarm_wr = 0;
    trace_done = 0; arm_wr = 1;
    model_step();
    @(negedge clk);
    check(lbl);
    cop_brk_req = 1; cop_brk_en = 1; bdm_sel = 1;
    model_step();
    @(negedge clk);
    check("R11");
    finish_run();
  end

endmodule